// File: doc/BRIEF.md
# Indirect Configuration Access Port Decoder

This block sits behind a host bridge's I/O decoder and provides the classic two-register indirect path into configuration space. Software first writes a 32-bit selector word into the address latch port. It then reads or writes the 4-byte data window. Each data-window access is turned into one request towards the configuration target. The request names a bus, an 8-bit device/function number and a register byte offset. The low bits of that offset come from the byte lane touched inside the data window.

The I/O side is a valid/ready request channel plus a valid/ready response channel. The block holds only one transaction at a time. `io_req_ready` is high only while the block is idle. A response stays valid, with its data unchanged, until `io_rsp_ready` is seen high at a clock edge. The configuration target cannot apply back-pressure. It receives a single-cycle request pulse. For a read, it answers later with `cfg_rsp_valid`, and a presence flag tells whether anything sits at the selected slot. A write is acknowledged on the I/O side at once.

Size codes on `io_req_size` and `cfg_req_size` are: 0 = one byte, 1 = two bytes, 2 = four bytes, 3 = illegal. Read data is always right-justified.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector latch holds zero, `io_req_ready` is 1, and both `io_rsp_valid` and `cfg_req_valid` are 0.
- R2: A 4-byte write at the latch port's base address (`ADDR_PORT_BASE`, default 0xCF8) stores all 32 bits. A 4-byte read there returns the last stored word, including bits 30:24, which have no other effect.
- R3: Any other access to the latch port has no effect on the latch, and a read of this kind returns 0. This covers sizes 0 and 1, and addresses 0xCF9 to 0xCFB.
- R4: Some data-port accesses are forwarded. This applies at `DATA_PORT_BASE` (default 0xCFC) to 0xCFF, with size 0, 1 or 2, when latch bit 31 is 1 and latch bits 1:0 are 0. Such an access raises `cfg_req_valid` for exactly one cycle, in the cycle after acceptance. The request carries bus = latch[23:16], devfn = latch[15:8] and offset = {latch[7:2], io address[1:0]}, with the same size, write flag and write data.
- R5: With latch bit 31 clear, a data-port access sends no request, a write is dropped and a read returns 0.
- R6: With latch bits 1:0 nonzero, a data-port access sends no request, a write is dropped and a read returns 0.
- R7: A forwarded read completes only after `cfg_rsp_valid`. If present is 1, its data is `cfg_rsp_rdata` masked to the size (low 8 bits for size 0, low 16 bits for size 1, all 32 for size 2). If present is 0, the data is 0.
- R8: Every write, and every access that is not forwarded, presents `io_rsp_valid` in the cycle after acceptance with no wait on the target. Its data is 0, except for an R2 latch read.
- R9: While `io_rsp_valid` is high and `io_rsp_ready` is low, the response and its data hold steady and `io_req_ready` stays 0.
- R10: An access to an address outside both ports, or a data-port access with size 3, sends no request, is dropped if it is a write and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | I/O request valid |
| io_req_ready | output | 1 | Block is idle and takes a request |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_addr | input | IO_AW | I/O byte address |
| io_req_size | input | 2 | Access size code |
| io_req_wdata | input | 32 | Right-justified write data |
| io_rsp_valid | output | 1 | Response valid |
| io_rsp_ready | input | 1 | Requester takes the response |
| io_rsp_rdata | output | 32 | Right-justified read data (0 for writes) |
| cfg_req_valid | output | 1 | One-cycle configuration request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_offset | output | 8 | Register byte offset |
| cfg_req_size | output | 2 | Access size code |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Read response from target |
| cfg_rsp_present | input | 1 | A device exists at the selected slot |
| cfg_rsp_rdata | input | 32 | Read data from target |

## Verification
Several properties are checked on every cycle:
- a target request lasts exactly one cycle;
- it only appears while the latch holds an enabled, aligned selector;
- its bus, devfn and upper offset bits match the latch;
- a write never waits for the target;
- a pending response is held stable under back-pressure;
- byte reads come back zero-extended.

Only the bench's sweeps can show the rest:
- the lane-to-offset merge for every lane and size;
- that a disabled or misaligned selector, an out-of-range address or an illegal size leaves the latch and target untouched;
- the presence-based zeroing;
- read latency as it follows a variable target delay.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } io_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } ctrl_state_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_LATCH_WR = 2'd1,
    ACT_LATCH_RD = 2'd2,
    ACT_FORWARD  = 2'd3
  } act_e;

  typedef struct packed {
    logic [7:0]    bus;
    logic [7:0]    devfn;
    logic [7:0]    offset;
    logic [1:0]    size;
    logic          write;
    logic [DW-1:0] wdata;
  } cfg_req_t;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= wr_data;
  end

  // R2: the selector only changes on a granted latch write
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int unsigned IO_AW          = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT_BASE = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT_BASE = 16'h0CFC
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic             io_write,
  input  logic [DW-1:0]    io_wdata,
  input  logic [DW-1:0]    latch_q,
  output act_e             act,
  output cfg_req_t         req
);

  localparam int unsigned PAGE_HI = IO_AW - 1;

  logic addr_hit, data_hit, latch_ok, size_ok;
  logic unused_hi;

  assign addr_hit = (io_addr[PAGE_HI:2] == ADDR_PORT_BASE[PAGE_HI:2]);
  assign data_hit = (io_addr[PAGE_HI:2] == DATA_PORT_BASE[PAGE_HI:2]);
  assign latch_ok = latch_q[31] && (latch_q[1:0] == 2'b00);
  assign size_ok  = (io_size != SZ_BAD);
  assign unused_hi = ^latch_q[30:24];

  always_comb begin
    act = ACT_NONE;
    if (addr_hit && io_size == SZ_WORD && io_addr[1:0] == 2'b00)
      act = io_write ? ACT_LATCH_WR : ACT_LATCH_RD;
    else if (data_hit && size_ok && latch_ok)
      act = ACT_FORWARD;
  end

  always_comb begin
    req.bus    = latch_q[23:16];
    req.devfn  = latch_q[15:8];
    req.offset = {latch_q[7:2], io_addr[1:0]};
    req.size   = io_size;
    req.write  = io_write;
    req.wdata  = io_wdata;
  end

endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req_valid,
  output logic          io_req_ready,
  input  act_e          act,
  input  cfg_req_t      req,
  input  logic [DW-1:0] latch_q,
  output logic          latch_wr_en,
  output logic          io_rsp_valid,
  input  logic          io_rsp_ready,
  output logic [DW-1:0] io_rsp_rdata,
  output logic          cfg_req_valid,
  output cfg_req_t      cfg_req_q,
  input  logic          cfg_rsp_valid,
  input  logic          cfg_rsp_present,
  input  logic [DW-1:0] cfg_rsp_rdata
);

  ctrl_state_e   state;
  logic [DW-1:0] rsp_data;
  logic          accept;

  assign io_req_ready = (state == ST_IDLE);
  assign accept       = io_req_valid && io_req_ready;
  assign latch_wr_en  = accept && (act == ACT_LATCH_WR);
  assign io_rsp_valid = (state == ST_RESP);
  assign io_rsp_rdata = rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      rsp_data      <= '0;
      cfg_req_valid <= 1'b0;
      cfg_req_q     <= '0;
    end else begin
      cfg_req_valid <= 1'b0;
      case (state)
        ST_IDLE: if (io_req_valid) begin
          rsp_data <= '0;
          state    <= ST_RESP;
          if (act == ACT_LATCH_RD) begin
            rsp_data <= latch_q;
          end else if (act == ACT_FORWARD) begin
            cfg_req_valid <= 1'b1;
            cfg_req_q     <= req;
            if (!req.write) state <= ST_WAIT;
          end
        end
        ST_WAIT: if (cfg_rsp_valid) begin
          rsp_data <= cfg_rsp_present ? (cfg_rsp_rdata & size_mask(cfg_req_q.size)) : '0;
          state    <= ST_RESP;
        end
        ST_RESP: if (io_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a target request is a single-cycle pulse
  a_r4_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |=> !cfg_req_valid);

  // R8: a forwarded write is acknowledged together with its request
  a_r8_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_req_q.write) |-> io_rsp_valid);

  // R9: a stalled response holds with its data
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid && !io_rsp_ready) |=> (io_rsp_valid && $stable(io_rsp_rdata)));

  // R9: no new request is taken while a response is pending
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid |-> !io_req_ready);

  // R7: byte reads come back zero-extended
  a_r7_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid && $past(state) == ST_WAIT && cfg_req_q.size == SZ_BYTE)
      |-> (io_rsp_rdata[31:8] == '0));

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgp_pkg::*;
#(
  parameter int unsigned IO_AW          = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT_BASE = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT_BASE = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req_valid,
  output logic             io_req_ready,
  input  logic             io_req_write,
  input  logic [IO_AW-1:0] io_req_addr,
  input  logic [1:0]       io_req_size,
  input  logic [31:0]      io_req_wdata,
  output logic             io_rsp_valid,
  input  logic             io_rsp_ready,
  output logic [31:0]      io_rsp_rdata,
  output logic             cfg_req_valid,
  output logic             cfg_req_write,
  output logic [7:0]       cfg_req_bus,
  output logic [7:0]       cfg_req_devfn,
  output logic [7:0]       cfg_req_offset,
  output logic [1:0]       cfg_req_size,
  output logic [31:0]      cfg_req_wdata,
  input  logic             cfg_rsp_valid,
  input  logic             cfg_rsp_present,
  input  logic [31:0]      cfg_rsp_rdata
);

  logic [DW-1:0] latch_q;
  logic          latch_wr_en;
  act_e          act;
  cfg_req_t      dec_req, cfg_req_q;

  cfgp_addr_latch #(.W(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(latch_wr_en),
    .wr_data(io_req_wdata), .q(latch_q)
  );

  cfgp_decode #(
    .IO_AW(IO_AW), .ADDR_PORT_BASE(ADDR_PORT_BASE), .DATA_PORT_BASE(DATA_PORT_BASE)
  ) u_decode (
    .io_addr(io_req_addr), .io_size(io_req_size), .io_write(io_req_write),
    .io_wdata(io_req_wdata), .latch_q(latch_q), .act(act), .req(dec_req)
  );

  cfgp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .act(act), .req(dec_req), .latch_q(latch_q), .latch_wr_en(latch_wr_en),
    .io_rsp_valid(io_rsp_valid), .io_rsp_ready(io_rsp_ready), .io_rsp_rdata(io_rsp_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_q(cfg_req_q),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_present(cfg_rsp_present),
    .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  assign cfg_req_write  = cfg_req_q.write;
  assign cfg_req_bus    = cfg_req_q.bus;
  assign cfg_req_devfn  = cfg_req_q.devfn;
  assign cfg_req_offset = cfg_req_q.offset;
  assign cfg_req_size   = cfg_req_q.size;
  assign cfg_req_wdata  = cfg_req_q.wdata;

  // R5 R6: requests only leave under an enabled, aligned selector
  a_r5_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (latch_q[31] && latch_q[1:0] == 2'b00));

  // R4: slot and upper offset bits follow the selector
  a_r4_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_bus == latch_q[23:16] && cfg_req_devfn == latch_q[15:8]
                       && cfg_req_offset[7:2] == latch_q[7:2]));

  // R10: an illegal size never reaches the target
  a_r10_no_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_size != 2'd3));

endmodule

// File: tb/cfg_port_decoder_tb.sv
module cfg_port_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req_valid = 1'b0, io_req_write = 1'b0, io_rsp_ready = 1'b0;
  logic [15:0] io_req_addr = '0;
  logic [1:0]  io_req_size = '0;
  logic [31:0] io_req_wdata = '0;
  logic        io_req_ready, io_rsp_valid;
  logic [31:0] io_rsp_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_req_bus, cfg_req_devfn, cfg_req_offset;
  logic [1:0]  cfg_req_size;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0, cfg_rsp_present = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  int checks = 0, failures = 0;
  int tgt_delay = 0;
  int n_cfg = 0;
  logic [7:0]  cap_bus, cap_devfn, cap_off;
  logic [1:0]  cap_size;
  logic        cap_wr;
  logic [31:0] cap_wdata;

  always #2.5 clk = ~clk;

  cfg_port_decoder dut_i (.*);

  function automatic logic [31:0] tgt_data(input logic [7:0] b, input logic [7:0] d, input logic [7:0] o);
    return {o ^ 8'h3C, d, b ^ 8'h5A, o};
  endfunction
  function automatic logic tgt_present(input logic [7:0] b, input logic [7:0] d);
    return (b < 8'd2) && (d[7:3] != 5'd31);
  endfunction
  function automatic logic [31:0] mask_of(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // request monitor, sampled between edges
  always @(negedge clk) if (rst_n && cfg_req_valid) begin
    n_cfg++;
    cap_bus = cfg_req_bus; cap_devfn = cfg_req_devfn; cap_off = cfg_req_offset;
    cap_size = cfg_req_size; cap_wr = cfg_req_write; cap_wdata = cfg_req_wdata;
  end

  // target model
  always begin
    @(negedge clk);
    if (rst_n && cfg_req_valid && !cfg_req_write) begin
      automatic logic [7:0] b = cfg_req_bus, d = cfg_req_devfn, o = cfg_req_offset;
      repeat (tgt_delay) @(negedge clk);
      cfg_rsp_valid = 1'b1;
      cfg_rsp_present = tgt_present(b, d);
      cfg_rsp_rdata = tgt_data(b, d, o);
      @(negedge clk);
      cfg_rsp_valid = 1'b0;
      cfg_rsp_present = 1'b0;
      cfg_rsp_rdata = 32'hDEAD_BEEF;
    end
  end

  task automatic io_txn(input logic w, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int hold,
                        output logic [31:0] rd, output int lat);
    logic [31:0] first;
    @(negedge clk);
    n_cfg = 0;
    check(io_req_ready, "R9 ready when idle", {31'b0, io_req_ready}, 32'd1);
    io_req_valid = 1'b1; io_req_write = w; io_req_addr = a; io_req_size = sz; io_req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
    lat = 1;
    while (!io_rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    first = io_rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(io_rsp_valid && io_rsp_rdata == first && !io_req_ready, "R9 response held",
            io_rsp_rdata, first);
    end
    rd = first;
    io_rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_rsp_ready = 1'b0;
    check(!io_rsp_valid && io_req_ready, "R9 response released", {31'b0, io_rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, sel, exp;
    int lat, idx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(io_req_ready && !io_rsp_valid && !cfg_req_valid, "R1 reset outputs",
          {29'b0, io_req_ready, io_rsp_valid, cfg_req_valid}, 32'd4);
    rst_n = 1'b1;
    io_txn(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    check(rd == 32'h0, "R1 latch clear after reset", rd, 32'h0);

    // R2 latch write/readback, including bits 30:24
    foreach (sel_pat[i]) begin
      io_txn(1'b1, 16'h0CF8, 2'd2, sel_pat[i], 0, rd, lat);
      io_txn(1'b0, 16'h0CF8, 2'd2, 0, 1, rd, lat);
      check(rd == sel_pat[i], "R2 latch readback", rd, sel_pat[i]);
      check(n_cfg == 0, "R2 no target request", n_cfg, 0);
    end

    // R3 improper latch-port accesses
    for (int off = 0; off < 4; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        if (off == 0 && sz == 2) continue;
        io_txn(1'b1, 16'h0CF8 + 16'(off), 2'(sz), 32'h1111_1111, 0, rd, lat);
        io_txn(1'b0, 16'h0CF8 + 16'(off), 2'(sz), 0, 0, rd, lat);
        check(rd == 0, "R3 improper latch read is zero", rd, 0);
      end
    end
    io_txn(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    check(rd == sel_pat[3], "R3 latch unchanged", rd, sel_pat[3]);

    // R4 R5 R6 R7 R8 sweep over enable, low bits, lane, size, direction
    idx = 0;
    for (int en = 0; en < 2; en++)
      for (int lo = 0; lo < 4; lo++)
        for (int ln = 0; ln < 4; ln++)
          for (int sz = 0; sz < 3; sz++)
            for (int w = 0; w < 2; w++) begin
              automatic logic [7:0] b = 8'(idx % 3);
              automatic logic [7:0] d = 8'(idx * 37);
              automatic logic [5:0] rg = 6'(idx * 5);
              automatic logic fwd = (en == 1) && (lo == 0);
              automatic logic [7:0] off = {rg, 2'(ln)};
              automatic logic [31:0] wd = 32'hA000_0000 + 32'(idx * 257);
              sel = {1'(en), 7'h55, b, d, rg, 2'(lo)};
              tgt_delay = idx % 4;
              io_txn(1'b1, 16'h0CF8, 2'd2, sel, 0, rd, lat);
              io_txn(1'(w), 16'h0CFC + 16'(ln), 2'(sz), wd, idx % 3, rd, lat);
              if (fwd) begin
                check(n_cfg == 1, "R4 one request", n_cfg, 1);
                check(cap_bus == b && cap_devfn == d, "R4 bus/devfn", {cap_bus, cap_devfn}, {b, d});
                check(cap_off == off, "R4 offset merge", cap_off, off);
                check(cap_size == 2'(sz) && cap_wr == 1'(w), "R4 size/dir",
                      {cap_size, cap_wr}, {2'(sz), 1'(w)});
                if (w == 1) check(cap_wdata == wd, "R4 write data", cap_wdata, wd);
              end else if (en == 0) begin
                check(n_cfg == 0, "R5 disabled no request", n_cfg, 0);
              end else begin
                check(n_cfg == 0, "R6 misaligned no request", n_cfg, 0);
              end
              if (w == 1 || !fwd) begin
                check(lat == 1, "R8 immediate response", lat, 1);
                check(rd == 0, w == 1 ? "R8 write rdata zero" : (en == 0 ? "R5 read zero" : "R6 read zero"), rd, 0);
              end else begin
                exp = tgt_present(b, d) ? (tgt_data(b, d, off) & mask_of(2'(sz))) : 32'h0;
                check(lat == 2 + tgt_delay, "R7 waits for target", lat, 2 + tgt_delay);
                check(rd == exp, "R7 read data", rd, exp);
              end
              idx++;
            end

    // R10 foreign address and illegal size
    io_txn(1'b1, 16'h0CF8, 2'd2, 32'h8000_1204, 0, rd, lat);
    io_txn(1'b0, 16'h0080, 2'd2, 0, 0, rd, lat);
    check(rd == 0 && n_cfg == 0, "R10 foreign read", rd, 0);
    io_txn(1'b1, 16'h0D00, 2'd2, 32'h7777_7777, 0, rd, lat);
    check(n_cfg == 0, "R10 foreign write no request", n_cfg, 0);
    io_txn(1'b0, 16'h0CFD, 2'd3, 0, 0, rd, lat);
    check(rd == 0 && n_cfg == 0, "R10 illegal size", rd, 0);
    io_txn(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    check(rd == 32'h8000_1204, "R10 latch untouched", rd, 32'h8000_1204);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [31:0] sel_pat [4] = '{32'hFFFF_FFFF, 32'h7F00_0000, 32'h81AB_CD7C, 32'h2A5A_A5F1};

endmodule